// File: doc/BRIEF.md
# 64-bit Virtual Address Segment Decoder

This block sorts a 64-bit virtual address into one of the architectural address regions and, for the regions that need no page table, forms the physical address directly. It sits between the address generation logic of a load/store or fetch path and the memory interface. The caller presents the address together with an access kind (fetch, load or store). The block returns either a physical address with a success flag, or an address-error code plus the faulting address, which is ready to be captured into the bad-address register.

Regions that would need a page-table lookup are not translated here. They are all folded into an address error whose code depends on the access kind. Cache-mode bits embedded in the direct-physical region are dropped. A parameter selects whether the results pass through one output register stage, for timing, or leave the block combinationally.

Top module: `va_seg_decoder`

## Requirements
- R1: An address whose bits 63..62 are 00 or 01 is rejected: ok is 0 and an address error is reported.
- R2: An address whose bits 63..62 are 10 is accepted. The physical address is bits 58..0 with bits 63..59 forced to zero, so bits 61..59 of the input have no effect on the result.
- R3: An address whose bits 63..62 are 11, whose bits 61..31 are all ones and whose bits 30..29 are 00 or 01 is accepted. The physical address is bits 28..0 with bits 63..29 forced to zero.
- R4: An address with bits 63..31 all ones and bits 30..29 equal to 10 or 11 is rejected.
- R5: An address with bits 63..62 equal to 11 and at least one zero in bits 61..31 is rejected.
- R6: The access kind is encoded as 00 fetch, 01 load, 10 store and 11 treated as load. On a rejection the 5-bit code is 0x05 for a store and 0x04 for every other kind. On acceptance the code is 0x00.
- R7: On a rejection the physical address is zero and the bad-address output equals the input address. On acceptance the bad-address output is zero.
- R8: With OUT_REG=1, all outputs appear one clock after the inputs are sampled, and out_valid repeats in_valid one cycle late. While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Active-low synchronous reset of the output stage |
| in_valid_i | input | 1 | Address and access kind are meaningful this cycle |
| vaddr_i | input | 64 | Virtual address to decode |
| acc_i | input | 2 | Access kind: 00 fetch, 01 load, 10 store, 11 load |
| out_valid_o | output | 1 | Results on the outputs are meaningful |
| paddr_o | output | 64 | Physical address, zero on rejection |
| ok_o | output | 1 | Translation succeeded |
| exc_code_o | output | 5 | Address-error code, zero on success |
| bad_vaddr_o | output | 64 | Faulting virtual address, zero on success |

## Verification
With the default single output stage, every result belongs to the inputs sampled at the previous rising edge. The driver applies inputs on the falling edge and queues the expected result at the same time. The monitor waits one time unit past each rising edge, and whenever out_valid is high it compares all outputs against the oldest queued item. Idle gaps with in_valid low must produce no result, and a result that arrives with nothing queued is flagged, so any extra or missing stage shows up as a mismatch.

// File: rtl/va_seg_pkg.sv
package va_seg_pkg;

  localparam int VA_W       = 64;
  localparam int CODE_W     = 5;
  localparam int XPHYS_TOP  = 58;
  localparam int COMPAT_TOP = 28;
  localparam int WIN_LO     = 31;
  localparam int WIN_HI     = 61;
  localparam int SEL_BIT    = 30;

  localparam logic [CODE_W-1:0] CODE_NONE  = 5'h00;
  localparam logic [CODE_W-1:0] CODE_LDERR = 5'h04;
  localparam logic [CODE_W-1:0] CODE_STERR = 5'h05;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [2:0] {
    SEG_USR     = 3'd0,
    SEG_SUP     = 3'd1,
    SEG_PHYS    = 3'd2,
    SEG_CMP_LOW = 3'd3,
    SEG_CMP_HI  = 3'd4,
    SEG_KMAP    = 3'd5
  } seg_e;

  // Keep bits [top:0] of a word and clear the rest.
  function automatic logic [VA_W-1:0] keep_low(input logic [VA_W-1:0] w,
                                               input int unsigned top);
    logic [VA_W-1:0] r;
    for (int i = 0; i < VA_W; i++) r[i] = (i <= int'(top)) ? w[i] : 1'b0;
    return r;
  endfunction

  function automatic logic [CODE_W-1:0] fault_code(input logic [1:0] acc);
    return (acc == ACC_STORE) ? CODE_STERR : CODE_LDERR;
  endfunction

endpackage

// File: rtl/va_region_classify.sv
module va_region_classify
  import va_seg_pkg::*;
(
  input  logic [VA_W-1:0] va_i,
  output seg_e            seg_o,
  output logic            win_hit_o
);
  always_comb begin
    win_hit_o = &va_i[WIN_HI:WIN_LO];
    unique case (va_i[VA_W-1:VA_W-2])
      2'b00:   seg_o = SEG_USR;
      2'b01:   seg_o = SEG_SUP;
      2'b10:   seg_o = SEG_PHYS;
      default: begin
        if (!win_hit_o)         seg_o = SEG_KMAP;
        else if (va_i[SEL_BIT]) seg_o = SEG_CMP_HI;
        else                    seg_o = SEG_CMP_LOW;
      end
    endcase
  end
endmodule

// File: rtl/va_phys_form.sv
module va_phys_form
  import va_seg_pkg::*;
(
  input  logic [VA_W-1:0] va_i,
  input  seg_e            seg_i,
  output logic [VA_W-1:0] pa_o,
  output logic            ok_o
);
  always_comb begin
    pa_o = '0;
    ok_o = 1'b0;
    case (seg_i)
      SEG_PHYS: begin
        pa_o = keep_low(va_i, XPHYS_TOP);
        ok_o = 1'b1;
      end
      SEG_CMP_LOW: begin
        pa_o = keep_low(va_i, COMPAT_TOP);
        ok_o = 1'b1;
      end
      default: begin
        pa_o = '0;
        ok_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/va_fault_encode.sv
module va_fault_encode
  import va_seg_pkg::*;
(
  input  logic [VA_W-1:0]   va_i,
  input  logic [1:0]        acc_i,
  input  logic              ok_i,
  output logic [CODE_W-1:0] code_o,
  output logic [VA_W-1:0]   bad_va_o
);
  always_comb begin
    code_o   = ok_i ? CODE_NONE : fault_code(acc_i);
    bad_va_o = ok_i ? '0 : va_i;
  end
endmodule

// File: rtl/va_seg_decoder.sv
module va_seg_decoder
  import va_seg_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [63:0]       vaddr_i,
  input  logic [1:0]        acc_i,
  output logic              out_valid_o,
  output logic [63:0]       paddr_o,
  output logic              ok_o,
  output logic [4:0]        exc_code_o,
  output logic [63:0]       bad_vaddr_o
);
  seg_e              seg_w;
  logic              win_hit_w;
  logic [VA_W-1:0]   pa_w;
  logic              ok_w;
  logic [CODE_W-1:0] code_w;
  logic [VA_W-1:0]   bad_w;

  va_region_classify u_cls (
    .va_i      (vaddr_i),
    .seg_o     (seg_w),
    .win_hit_o (win_hit_w)
  );

  va_phys_form u_pa (
    .va_i  (vaddr_i),
    .seg_i (seg_w),
    .pa_o  (pa_w),
    .ok_o  (ok_w)
  );

  va_fault_encode u_flt (
    .va_i     (vaddr_i),
    .acc_i    (acc_i),
    .ok_i     (ok_w),
    .code_o   (code_w),
    .bad_va_o (bad_w)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
          out_valid_o <= 1'b0;
          paddr_o     <= '0;
          ok_o        <= 1'b0;
          exc_code_o  <= '0;
          bad_vaddr_o <= '0;
        end else begin
          out_valid_o <= in_valid_i;
          paddr_o     <= in_valid_i ? pa_w   : '0;
          ok_o        <= in_valid_i & ok_w;
          exc_code_o  <= in_valid_i ? code_w : '0;
          bad_vaddr_o <= in_valid_i ? bad_w  : '0;
        end
      end
    end else begin : g_comb
      always_comb begin
        out_valid_o = in_valid_i;
        paddr_o     = pa_w;
        ok_o        = ok_w;
        exc_code_o  = code_w;
        bad_vaddr_o = bad_w;
      end
    end
  endgenerate
endmodule

// File: rtl/va_seg_decoder_chk.sv
module va_seg_decoder_chk
  import va_seg_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        out_valid_o,
  input logic [63:0] paddr_o,
  input logic        ok_o,
  input logic [4:0]  exc_code_o,
  input logic [63:0] bad_vaddr_o,
  input seg_e        seg_w,
  input logic        ok_w
);
  a_r1_user_sup_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && (seg_w == SEG_USR || seg_w == SEG_SUP) |-> !ok_w);

  a_r5_kmap_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && seg_w == SEG_KMAP |-> !ok_w);

  a_r2_phys_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && ok_o |-> paddr_o[63:59] == 5'd0);

  a_r6_code_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !ok_o |-> (exc_code_o == CODE_LDERR || exc_code_o == CODE_STERR));

  a_r7_ok_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && ok_o |-> exc_code_o == CODE_NONE && bad_vaddr_o == '0);

  a_r7_err_no_pa: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !ok_o |-> paddr_o == '0);

  generate
    if (OUT_REG) begin : g_lat
      a_r8_valid_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> out_valid_o == $past(in_valid_i));
    end
  endgenerate
endmodule

bind va_seg_decoder va_seg_decoder_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .paddr_o     (paddr_o),
  .ok_o        (ok_o),
  .exc_code_o  (exc_code_o),
  .bad_vaddr_o (bad_vaddr_o),
  .seg_w       (seg_w),
  .ok_w        (ok_w)
);

// File: tb/va_seg_decoder_tb.sv
module va_seg_decoder_tb;
  typedef struct {
    logic [63:0] pa;
    logic        ok;
    logic [4:0]  code;
    logic [63:0] bad;
    string       req;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [63:0] vaddr_i = '0;
  logic [1:0]  acc_i = '0;
  logic        out_valid_o;
  logic [63:0] paddr_o;
  logic        ok_o;
  logic [4:0]  exc_code_o;
  logic [63:0] bad_vaddr_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  exp_t sb[$];

  always #2 clk_i = ~clk_i;

  va_seg_decoder u_dut (.*);

  // Reference: segment rules restated from the requirements.
  function automatic exp_t model(input logic [63:0] va, input logic [1:0] acc,
                                 input string req);
    exp_t e;
    logic accept;
    logic [63:0] pa;
    accept = 1'b0;
    pa = 64'd0;
    if (va[63:62] == 2'b10) begin
      accept = 1'b1;
      pa = va & 64'h07FF_FFFF_FFFF_FFFF;
    end else if (va[63:31] == {33{1'b1}} && va[30] == 1'b0) begin
      accept = 1'b1;
      pa = va & 64'h0000_0000_1FFF_FFFF;
    end
    e.ok   = accept;
    e.pa   = pa;
    e.code = accept ? 5'd0 : ((acc == 2'b10) ? 5'd5 : 5'd4);
    e.bad  = accept ? 64'd0 : va;
    e.req  = req;
    return e;
  endfunction

  task automatic send(input logic [63:0] va, input logic [1:0] acc, input string req);
    @(negedge clk_i);
    vaddr_i    = va;
    acc_i      = acc;
    in_valid_i = 1'b1;
    sb.push_back(model(va, acc, req));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      in_valid_i = 1'b0;
      vaddr_i    = 64'hDEAD_BEEF_0000_0001;
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Monitor: one time unit after each rising edge.
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (rst_ni && out_valid_o) begin
        total++;
        if (sb.size() == 0) begin
          bad++;
          $display("FAIL R8: result with nothing queued, actual pa=%h expected none", paddr_o);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (paddr_o !== e.pa || ok_o !== e.ok || exc_code_o !== e.code ||
              bad_vaddr_o !== e.bad) begin
            bad++;
            $display("FAIL %s: actual pa=%h ok=%b code=%h bad=%h expected pa=%h ok=%b code=%h bad=%h",
                     e.req, paddr_o, ok_o, exc_code_o, bad_vaddr_o,
                     e.pa, e.ok, e.code, e.bad);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    total++;
    if (out_valid_o !== 1'b0 || paddr_o !== '0 || ok_o !== 1'b0 ||
        exc_code_o !== '0 || bad_vaddr_o !== '0) begin
      bad++;
      $display("FAIL R8: reset outputs actual v=%b pa=%h ok=%b code=%h expected all zero",
               out_valid_o, paddr_o, ok_o, exc_code_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    send(64'h0000_0000_1234_5678, 2'b01, "R1");
    send(64'h4000_0000_0000_1000, 2'b10, "R1");
    send(64'h7FFF_FFFF_FFFF_FFFF, 2'b00, "R1");
    send(64'h9800_0000_1234_5678, 2'b01, "R2");
    send(64'h8000_0000_1234_5678, 2'b01, "R2");
    send(64'hBFFF_FFFF_FFFF_FFFF, 2'b10, "R2");
    idle(2);
    send(64'hFFFF_FFFF_8000_1000, 2'b00, "R3");
    send(64'hFFFF_FFFF_A000_0040, 2'b10, "R3");
    send(64'hFFFF_FFFF_BFFF_FFFF, 2'b01, "R3");
    send(64'hFFFF_FFFF_C000_0000, 2'b01, "R4");
    send(64'hFFFF_FFFF_E000_0008, 2'b10, "R4");
    send(64'hFFFF_FFFF_7FFF_FFFF, 2'b01, "R5");
    send(64'hC000_0000_0000_0000, 2'b10, "R5");
    send(64'hFFFF_FFFE_8000_0000, 2'b00, "R5");
    idle(1);
    send(64'h0000_0000_0000_0004, 2'b00, "R6");
    send(64'h0000_0000_0000_0004, 2'b11, "R6");
    send(64'h0000_0000_0000_0004, 2'b10, "R6");
    send(64'h5555_AAAA_5555_AAAA, 2'b10, "R7");
    for (int i = 0; i < 300; i++) begin
      logic [63:0] va;
      va = {$urandom, $urandom};
      case (i % 4)
        0: va[63:31] = {33{1'b1}};
        1: va[63:62] = 2'b10;
        default: ;
      endcase
      send(va, 2'($urandom), "R7");
      if (i % 7 == 0) idle(1);
    end
    idle(3);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R8: missing results actual=%0d expected 0 pending", sb.size());
    end
    finish_run();
  end
endmodule